// File: doc/BRIEF.md
# Serial Video Bit-Stream Decoder and Word Framer

This block sits behind a clock and data recovery stage in a serial digital video receiver. It takes one recovered line bit each time `bit_en` is high, at ten times the word rate. By default it undoes the channel coding in two steps. First it decodes the transition code: each decoded bit is the XOR of the current line bit and the previous line bit. Then it runs a self-synchronising descrambler for the polynomial x^9 + x^4 + 1. The decoded bits then go to a word framer, which builds 10-bit parallel words and gives one strobe per word.

The framer finds the word boundary from the video timing reference preamble: one word of all ones followed by two words of all zeros. It keeps a 30-bit window of the most recent decoded bits and tests it for this pattern. When the preamble lands on a different bit phase from the current boundary, the boundary does not move on that first sighting. It moves only when the next preamble confirms the same new phase, so a single false match cannot upset the alignment.

One control input, `raw_mode`, is active high. When it is high, both the transition decoding and the descrambling are switched off, and the raw line bits go straight to the framer. The framer still aligns to the preamble in this mode.

Top module: `sdi_rx_deframer`

## Requirements
- R1: During and after reset, `word_vld` is 0 and `word_out` is 0 until the first word completes. The first word boundary falls after the tenth accepted bit following reset.
- R2: With `raw_mode` low, each decoded bit is the current line bit XOR the previous accepted line bit. The previous line bit is 0 after reset.
- R3: With `raw_mode` low, the transition-decoded bit is descrambled. The result is that bit XOR the transition-decoded bits from 4 and from 9 accepted bits earlier, and this history is all zeros after reset. The result is the stream a scrambler would have received, where that scrambler sends data XOR its own outputs 4 and 9 bits back.
- R4: With `raw_mode` high, the transition decoding and the descrambling are both bypassed. Each framed bit equals the line bit as it is given.
- R5: Words are assembled least significant bit first: the earliest bit of a word lands in `word_out[0]`. `word_vld` pulses for one clock in the cycle right after the clock edge that accepts the word's last bit. `word_out` changes only on such a pulse.
- R6: The block ignores `line_bit` in any cycle where `bit_en` is low.
- R7: The preamble is ten ones (0x3FF) followed by twenty zeros (0x000, 0x000), seen in arrival order. When a preamble ends exactly on the current word boundary, the boundary stays where it is, and the final 0x000 word is emitted on that boundary.
- R8: The preamble can end on a phase other than the current boundary. If the previous preamble ended on that same phase, the boundary moves: the final 0x000 word is emitted on that bit at once, and the next word starts with the following bit.
- R9: A preamble at a new phase is not acted on when it is the first sighting, or when it follows a preamble at a different phase. In that case the words keep their old boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, runs at or above the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Marks a cycle that carries a valid line bit |
| line_bit | input | 1 | Recovered serial line bit |
| raw_mode | input | 1 | High: bypass transition decoding and descrambling |
| word_out | output | 10 | Assembled parallel word, earliest bit in bit 0 |
| word_vld | output | 1 | One-clock strobe marking a new `word_out` |

## Verification
Two events can fall on the same bit. One is the end of a preamble at a new phase, which moves the boundary. The other is the ordinary end-of-word count at the old phase. The bench provokes this conflict by inserting zero bits before a preamble, so that the preamble ends away from the current boundary. It then sends the preamble once or twice, and also at two different phases. The scoreboard computes each expected word and its exact strobe cycle from its own copy of the bit stream and the boundary the requirements give. So a word emitted at the wrong phase, or a boundary that moves too early or too late, shows up as a value or timing mismatch.

// File: rtl/sdi_rx_pkg.sv
package sdi_rx_pkg;

   localparam int DEF_WORD_W    = 10;
   localparam int DEF_TAP_NEAR  = 4;
   localparam int DEF_TAP_FAR   = 9;
   localparam int DEF_PRE_WORDS = 3;
   localparam int DEF_CONFIRM   = 2;

   typedef enum logic {
      MODE_CODED = 1'b0,
      MODE_RAW   = 1'b1
   } rx_mode_e;

   typedef enum logic [1:0] {
      PRE_NONE    = 2'd0,
      PRE_ON_GRID = 2'd1,
      PRE_OFF_NEW = 2'd2,
      PRE_OFF_OK  = 2'd3
   } pre_kind_e;

endpackage

// File: rtl/sdi_nrzi_stage.sv
module sdi_nrzi_stage #(
   parameter bit HAS_DECODE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_en,
   input  logic enable,
   input  logic din,
   output logic dout
);

   generate
      if (HAS_DECODE) begin : g_decode
         logic prev_line;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               prev_line <= 1'b0;
            end else if (bit_en) begin
               prev_line <= din;
            end
         end

         assign dout = enable ? (din ^ prev_line) : din;
      end else begin : g_pass
         assign dout = din;
      end
   endgenerate

endmodule

// File: rtl/sdi_descram_stage.sv
module sdi_descram_stage #(
   parameter int TAP_NEAR = 4,
   parameter int TAP_FAR  = 9
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_en,
   input  logic enable,
   input  logic din,
   output logic dout
);

   localparam int HIST_W = TAP_FAR;

   generate
      if (TAP_NEAR < 1) begin : g_bad_near
         $error("sdi_descram_stage: TAP_NEAR must be at least 1");
      end
      if (TAP_FAR <= TAP_NEAR) begin : g_bad_far
         $error("sdi_descram_stage: TAP_FAR must exceed TAP_NEAR");
      end
   endgenerate

   logic [HIST_W-1:0] hist;
   logic              fb;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist <= '0;
      end else if (bit_en) begin
         hist <= {hist[HIST_W-2:0], din};
      end
   end

   assign fb   = hist[TAP_NEAR-1] ^ hist[TAP_FAR-1];
   assign dout = enable ? (din ^ fb) : din;

endmodule

// File: rtl/sdi_word_framer.sv
module sdi_word_framer
   import sdi_rx_pkg::*;
#(
   parameter int WORD_W    = 10,
   parameter int PRE_WORDS = 3,
   parameter int CONFIRM_N = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       bit_en,
   input  logic                       din,
   output logic [WORD_W-1:0]          word_out,
   output logic                       word_vld,
   output logic [$clog2(WORD_W)-1:0]  slot_o,
   output logic                       hit_o
);

   localparam int CW     = $clog2(WORD_W);
   localparam int WIN_W  = WORD_W * PRE_WORDS;
   localparam int CFW    = $clog2(CONFIRM_N + 1);
   localparam logic [CW-1:0]    LAST_SLOT = CW'(WORD_W - 1);
   localparam logic [CFW-1:0]   CONF_LAST = CFW'(CONFIRM_N - 1);
   localparam logic [WIN_W-1:0] PRE_PAT   =
      {{(WIN_W - WORD_W){1'b0}}, {WORD_W{1'b1}}};

   generate
      if (WORD_W < 2) begin : g_bad_w
         $error("sdi_word_framer: WORD_W must be at least 2");
      end
      if (PRE_WORDS < 2) begin : g_bad_pre
         $error("sdi_word_framer: PRE_WORDS must be at least 2");
      end
      if (CONFIRM_N < 1) begin : g_bad_conf
         $error("sdi_word_framer: CONFIRM_N must be at least 1");
      end
   endgenerate

   logic [WIN_W-2:0] win;
   logic [WIN_W-1:0] win_next;
   logic [CW-1:0]    slot;
   logic             pend_vld;
   logic [CW-1:0]    pend_phase;
   logic [CFW-1:0]   pend_cnt;
   logic             hit;
   logic             at_end;
   logic             confirmed;
   pre_kind_e        kind;

   assign win_next = {din, win};
   assign hit      = (win_next == PRE_PAT);
   assign at_end   = (slot == LAST_SLOT);

   generate
      if (CONFIRM_N == 1) begin : g_conf_one
         assign confirmed = 1'b1;
      end else begin : g_conf_many
         assign confirmed = pend_vld && (pend_phase == slot) && (pend_cnt == CONF_LAST);
      end
   endgenerate

   always_comb begin
      kind = PRE_NONE;
      if (bit_en && hit) begin
         if (at_end) begin
            kind = PRE_ON_GRID;
         end else if (confirmed) begin
            kind = PRE_OFF_OK;
         end else begin
            kind = PRE_OFF_NEW;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win      <= '0;
         slot     <= '0;
         word_out <= '0;
         word_vld <= 1'b0;
      end else begin
         word_vld <= 1'b0;
         if (bit_en) begin
            win <= win_next[WIN_W-1:1];
            if (at_end || (kind == PRE_OFF_OK)) begin
               word_out <= win_next[WIN_W-1 -: WORD_W];
               word_vld <= 1'b1;
               slot     <= '0;
            end else begin
               slot <= slot + CW'(1);
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_vld   <= 1'b0;
         pend_phase <= '0;
         pend_cnt   <= '0;
      end else begin
         case (kind)
            PRE_ON_GRID, PRE_OFF_OK: begin
               pend_vld <= 1'b0;
               pend_cnt <= '0;
            end
            PRE_OFF_NEW: begin
               if (pend_vld && (pend_phase == slot)) begin
                  pend_cnt <= pend_cnt + CFW'(1);
               end else begin
                  pend_vld   <= 1'b1;
                  pend_phase <= slot;
                  pend_cnt   <= CFW'(1);
               end
            end
            default: begin
            end
         endcase
      end
   end

   assign slot_o = slot;
   assign hit_o  = hit;

endmodule

// File: rtl/sdi_rx_deframer.sv
module sdi_rx_deframer
   import sdi_rx_pkg::*;
#(
   parameter int WORD_W    = DEF_WORD_W,
   parameter int TAP_NEAR  = DEF_TAP_NEAR,
   parameter int TAP_FAR   = DEF_TAP_FAR,
   parameter int PRE_WORDS = DEF_PRE_WORDS,
   parameter int CONFIRM_N = DEF_CONFIRM
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_en,
   input  logic              line_bit,
   input  logic              raw_mode,
   output logic [WORD_W-1:0] word_out,
   output logic              word_vld
);

   localparam int CW = $clog2(WORD_W);

   generate
      if (WORD_W > 64) begin : g_bad_width
         $error("sdi_rx_deframer: WORD_W above 64 is not supported");
      end
   endgenerate

   rx_mode_e       mode;
   logic           coded;
   logic           trans_bit;
   logic           clean_bit;
   logic [CW-1:0]  slot;
   logic           pre_hit;

   assign mode  = rx_mode_e'(raw_mode);
   assign coded = (mode == MODE_CODED);

   sdi_nrzi_stage #(
      .HAS_DECODE (1'b1)
   ) u_nrzi (
      .clk    (clk),
      .rst_n  (rst_n),
      .bit_en (bit_en),
      .enable (coded),
      .din    (line_bit),
      .dout   (trans_bit)
   );

   sdi_descram_stage #(
      .TAP_NEAR (TAP_NEAR),
      .TAP_FAR  (TAP_FAR)
   ) u_descram (
      .clk    (clk),
      .rst_n  (rst_n),
      .bit_en (bit_en),
      .enable (coded),
      .din    (trans_bit),
      .dout   (clean_bit)
   );

   sdi_word_framer #(
      .WORD_W    (WORD_W),
      .PRE_WORDS (PRE_WORDS),
      .CONFIRM_N (CONFIRM_N)
   ) u_framer (
      .clk      (clk),
      .rst_n    (rst_n),
      .bit_en   (bit_en),
      .din      (clean_bit),
      .word_out (word_out),
      .word_vld (word_vld),
      .slot_o   (slot),
      .hit_o    (pre_hit)
   );

endmodule

// File: rtl/sdi_rx_deframer_chk.sv
module sdi_rx_deframer_chk #(
   parameter int WORD_W = 10
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       bit_en,
   input logic                       line_bit,
   input logic                       raw_mode,
   input logic                       clean_bit,
   input logic [$clog2(WORD_W)-1:0]  slot,
   input logic                       pre_hit,
   input logic [WORD_W-1:0]          word_out,
   input logic                       word_vld
);

   localparam int CW = $clog2(WORD_W);

   AST_RAW_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      raw_mode |-> (clean_bit == line_bit)); // R4

   AST_STB_NEEDS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      word_vld |-> $past(bit_en)); // R6

   AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !word_vld |-> $stable(word_out)); // R5

   AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      slot <= CW'(WORD_W - 1)); // R5

   AST_GRID_PREAMBLE: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_en && pre_hit && (slot == CW'(WORD_W - 1))) |=> (word_vld && (word_out == '0))); // R7

endmodule

bind sdi_rx_deframer sdi_rx_deframer_chk #(
   .WORD_W (WORD_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bit_en    (bit_en),
   .line_bit  (line_bit),
   .raw_mode  (raw_mode),
   .clean_bit (clean_bit),
   .slot      (slot),
   .pre_hit   (pre_hit),
   .word_out  (word_out),
   .word_vld  (word_vld)
);

// File: tb/tb_sdi_rx_deframer.sv
module tb_sdi_rx_deframer;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bit_en = 1'b0;
   logic       line_bit = 1'b0;
   logic       raw_mode = 1'b0;
   logic [9:0] word_out;
   logic       word_vld;

   typedef struct {
      logic [9:0] w;
      int         due;
   } exp_t;

   exp_t       sbq[$];
   logic       plain[$];
   int         anchor = 0;
   int         cyc = 0;
   int         checks = 0;
   int         errors = 0;
   bit         running = 1'b0;
   bit         finished = 1'b0;
   logic [8:0] sh = '0;
   logic       prev_line = 1'b0;
   logic [9:0] last_word = '0;
   string      req = "R5";

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   sdi_rx_deframer dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .bit_en   (bit_en),
      .line_bit (line_bit),
      .raw_mode (raw_mode),
      .word_out (word_out),
      .word_vld (word_vld)
   );

   task automatic push_expected(input int idx);
      exp_t e;
      for (int k = 0; k < 10; k++) e.w[k] = plain[idx - 9 + k];
      e.due = cyc + 1;
      sbq.push_back(e);
   endtask

   task automatic send_bit(input logic b, input bit reanchor);
      logic s;
      logic ln;
      int   idx;
      int   g;
      @(negedge clk);
      if (raw_mode) begin
         ln = b;
      end else begin
         s  = b ^ sh[3] ^ sh[8];
         sh = {sh[7:0], s};
         ln = prev_line ^ s;
      end
      prev_line = ln;
      line_bit  = ln;
      bit_en    = 1'b1;
      plain.push_back(b);
      idx = plain.size() - 1;
      if (reanchor) begin
         push_expected(idx);
         anchor = idx + 1;
      end else if (idx >= anchor && ((idx - anchor) % 10) == 9) begin
         push_expected(idx);
      end
      g = $urandom_range(0, 2);
      repeat (g) begin
         @(negedge clk);
         bit_en   = 1'b0;
         line_bit = 1'($urandom);
      end
   endtask

   task automatic send_word(input logic [9:0] w, input bit reanchor_last);
      for (int k = 0; k < 10; k++) send_bit(w[k], reanchor_last && (k == 9));
   endtask

   task automatic send_pre(input bit reanchor);
      send_word(10'h3FF, 1'b0);
      send_word(10'h000, 1'b0);
      send_word(10'h000, reanchor);
   endtask

   task automatic slip(input int n);
      for (int k = 0; k < n; k++) send_bit(1'b0, 1'b0);
   endtask

   task automatic idle(input int n);
      repeat (n) begin
         @(negedge clk);
         bit_en   = 1'b0;
         line_bit = 1'($urandom);
      end
   endtask

   task automatic report;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (running && rst_n) begin
         if (word_vld) begin
            checks++;
            if (sbq.size() == 0) begin
               errors++;
               $display("FAIL %s: unexpected strobe, word %h, expected none", req, word_out);
            end else begin
               exp_t e;
               e = sbq.pop_front();
               if (word_out !== e.w || cyc != e.due) begin
                  errors++;
                  $display("FAIL %s: word %h at cycle %0d, expected %h at cycle %0d",
                           req, word_out, cyc, e.w, e.due);
               end
            end
            last_word = word_out;
         end else begin
            checks++;
            if (word_out !== last_word) begin
               errors++;
               $display("FAIL R5: word_out changed without strobe, got %h expected %h",
                        word_out, last_word);
            end
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run hung, got timeout expected completion");
         report();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset values
      checks++;
      if (word_vld !== 1'b0 || word_out !== 10'h000) begin
         errors++;
         $display("FAIL R1: vld %b word %h in reset, expected 0 000", word_vld, word_out);
      end
      rst_n = 1'b1;
      @(negedge clk);
      checks++;
      if (word_vld !== 1'b0 || word_out !== 10'h000) begin
         errors++;
         $display("FAIL R1: vld %b word %h after reset, expected 0 000", word_vld, word_out);
      end
      running = 1'b1;

      // R2 R3 R5 R6 R7: coded stream on the reset boundary, gaps with noise
      req = "R2/R3/R5/R6/R7";
      send_pre(1'b0);
      send_word(10'h155, 1'b0);
      send_word(10'h2AA, 1'b0);
      send_word(10'h0CC, 1'b0);
      send_word(10'h333, 1'b0);
      send_word(10'h123, 1'b0);
      send_word(10'h0F0, 1'b0);

      // R9 then R8: same new phase twice
      req = "R8/R9 phase repeat";
      slip(3);
      send_pre(1'b0);
      send_word(10'h155, 1'b0);
      send_word(10'h2AA, 1'b0);
      send_pre(1'b1);
      send_word(10'h0CC, 1'b0);
      send_word(10'h333, 1'b0);
      send_word(10'h155, 1'b0);

      // R9: two different new phases, then a confirming third
      req = "R9/R8 phase change";
      slip(4);
      send_pre(1'b0);
      send_word(10'h2AA, 1'b0);
      slip(2);
      send_pre(1'b0);
      send_word(10'h155, 1'b0);
      send_pre(1'b1);
      send_word(10'h333, 1'b0);
      send_word(10'h0CC, 1'b0);

      // R4: raw bypass, alignment still works
      idle(2);
      raw_mode = 1'b1;
      req = "R4/R7 raw";
      send_word(10'h155, 1'b0);
      send_pre(1'b0);
      send_word(10'h2AA, 1'b0);
      req = "R4/R8 raw";
      slip(7);
      send_pre(1'b0);
      send_word(10'h0F0, 1'b0);
      send_pre(1'b1);
      send_word(10'h123, 1'b0);
      send_word(10'h333, 1'b0);
      idle(6);

      checks++;
      if (sbq.size() != 0) begin
         errors++;
         $display("FAIL R5: %0d expected words never strobed, expected 0", sbq.size());
      end
      finished = 1'b1;
      report();
      $finish;
   end

endmodule